// File: doc/BRIEF.md
# Vectored Interrupt Dispatcher With Remap

This block sits between sixteen level-sensitive legacy device interrupt lines and a processor that takes vectored interrupts. A small fixed table translates five of the legacy lines into interrupt vector numbers in a 64-entry vector space. The remaining lines have no translation and are ignored. A recognised line that rises is delivered through a single-slot mailbox. The block sets a busy flag and loads a three-word mailbox: the first word carries a fixed tag above the vector number, and the other two words are zero. It also raises a hard-interrupt request, presents the vector trap code and pulses a wake signal that ends any halted state.

Only one vector is outstanding at a time. A raise that arrives while the slot is occupied is dropped, not queued. Lowering the line that owns the slot frees it and withdraws the request. Lines that rise together while the slot is free are held as pending for as long as they stay high. They are then delivered one after another, lowest line number first.

Top module: `ivd_dispatch`

## Requirements
- R1: The translation is line 1 to vector 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. Mailbox word 0 equals (0x1F << 6) | vector, which gives 0x7E9, 0x7EB, 0x7E7, 0x7E2 and 0x7EA for those lines.
- R2: A rise or fall on any other line (0, 2, 3, 5, 8 to 11, 13 to 15) changes no output.
- R3: One clock edge after a recognised line rises with the slot free, busy_o and irq_req_o are 1 and trap_type_o equals TRAP_CODE (default 0x060). Word 0 is loaded as in R1, and words 1 and 2 are 0. The words keep their values until the next delivery.
- R4: wake_o is high for exactly one cycle, the cycle in which a delivery first shows on the outputs.
- R5: A recognised line that rises while busy_o is 1 is never delivered, even if it stays high after the slot frees. The mailbox words stay unchanged while busy.
- R6: One edge after the delivered line goes low, busy_o and irq_req_o are 0 and trap_type_o is 0. Lowering any other line leaves the slot busy.
- R7: Recognised lines that rise in the same cycle with the slot free are delivered lowest line number first. Each later one is delivered one edge after the previous slot is freed, provided its line is still high.
- R8: A pending line that goes low before its delivery is discarded.
- R9: Reset (rst_n low, acting at once) clears busy_o, irq_req_o, trap_type_o, wake_o and all three mailbox words.
- R10: When the delivered line falls in the same cycle that another recognised line rises, the new rise is dropped, because the slot still counts as busy in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_irq_i | input | N_LINES | Legacy device interrupt levels, synchronous to clk |
| busy_o | output | 1 | Mailbox slot occupied |
| mbox_w0_o | output | WORD_W | Mailbox word 0: tag 0x1F above the vector number |
| mbox_w1_o | output | WORD_W | Mailbox word 1, zero on delivery |
| mbox_w2_o | output | WORD_W | Mailbox word 2, zero on delivery |
| irq_req_o | output | 1 | Hard-interrupt request to the processor |
| trap_type_o | output | TRAP_W | Vector trap code while a vector is outstanding, else zero |
| wake_o | output | 1 | One-cycle pulse on delivery, ends a halted state |

## Verification
The freeing of the slot and the acceptance of a new raise can fall into the same cycle. The bench lowers the owning line and raises another recognised line on the same falling clock edge. The scoreboard must then see no delivery, and busy must stay low afterwards even though the new line is still high (R10). The same raise issued one cycle later must be delivered. The bench also raises three recognised lines at once and judges the order of the scoreboard pops against the lowest-line-first rule (R7).

// File: rtl/ivd_pkg.sv
package ivd_pkg;

  localparam int unsigned VEC_SPACE = 64;
  localparam int unsigned VEC_BITS  = $clog2(VEC_SPACE);
  localparam logic [4:0]  MB_TAG    = 5'h1F;

  typedef struct packed {
    logic                hit;
    logic [VEC_BITS-1:0] vec;
  } route_t;

  // Fixed legacy-line translation; lines not listed have no vector.
  function automatic route_t route_of(input int unsigned line);
    route_t r;
    r.hit = 1'b1;
    case (line)
      1:       r.vec = 6'h29;
      4:       r.vec = 6'h2B;
      6:       r.vec = 6'h27;
      7:       r.vec = 6'h22;
      12:      r.vec = 6'h2A;
      default: begin
        r.hit = 1'b0;
        r.vec = '0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ivd_line_track.sv
module ivd_line_track #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] mapped,
  input  logic         busy,
  input  logic [N-1:0] grant,
  output logic [N-1:0] cand
);

  logic [N-1:0] line_q, pend_q;
  logic [N-1:0] rise, pend_n;

  always_comb begin
    rise   = lines & ~line_q & mapped;
    cand   = (pend_q | (rise & {N{~busy}})) & lines;
    pend_n = cand & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      pend_q <= '0;
    end else begin
      line_q <= lines;
      pend_q <= pend_n;
    end
  end

  // R8: a pending bit never survives its line going low
  a_r8_pend_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~lines) != '0) |=> ((pend_q & ~$past(lines)) == '0));

endmodule

// File: rtl/ivd_pick.sv
module ivd_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic         enable,
  input  logic [N-1:0] cand,
  output logic [N-1:0] grant,
  output logic [IW-1:0] idx,
  output logic         any
);

  logic [N:0] below;

  assign below[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chain
      assign below[i+1] = below[i] | cand[i];
      assign grant[i]   = enable & cand[i] & ~below[i];
    end
  endgenerate

  assign any = |grant;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/ivd_mailbox.sv
module ivd_mailbox #(
  parameter int unsigned N         = 16,
  parameter int unsigned VEC_W     = 6,
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned TRAP_W    = 9,
  parameter logic [TRAP_W-1:0] TRAP_CODE = 9'h060,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IW-1:0]     fire_idx,
  input  logic [VEC_W-1:0]  fire_vec,
  input  logic [N-1:0]      lines,
  output logic              busy,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1,
  output logic [WORD_W-1:0] w2,
  output logic              irq_req,
  output logic [TRAP_W-1:0] trap_type,
  output logic              wake
);

  logic              busy_q, busy_n;
  logic [IW-1:0]     act_q, act_n;
  logic [WORD_W-1:0] w0_q, w0_n, w1_q, w1_n, w2_q, w2_n;
  logic              wake_q, wake_n;
  logic              release_now;

  always_comb begin
    release_now = busy_q & ~lines[act_q];
    busy_n = busy_q;
    act_n  = act_q;
    w0_n   = w0_q;
    w1_n   = w1_q;
    w2_n   = w2_q;
    wake_n = 1'b0;
    if (fire) begin
      busy_n = 1'b1;
      act_n  = fire_idx;
      w0_n   = (WORD_W'(ivd_pkg::MB_TAG) << VEC_W) | WORD_W'(fire_vec);
      w1_n   = '0;
      w2_n   = '0;
      wake_n = 1'b1;
    end else if (release_now) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      w2_q   <= '0;
      wake_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      act_q  <= act_n;
      w0_q   <= w0_n;
      w1_q   <= w1_n;
      w2_q   <= w2_n;
      wake_q <= wake_n;
    end
  end

  assign busy      = busy_q;
  assign w0        = w0_q;
  assign w1        = w1_q;
  assign w2        = w2_q;
  assign irq_req   = busy_q;
  assign trap_type = busy_q ? TRAP_CODE : '0;
  assign wake      = wake_q;

  // R3: while busy, word 0 carries the tag and the other words are zero
  a_r3_word_form: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (w0_q[VEC_W+4:VEC_W] == ivd_pkg::MB_TAG && w1_q == '0 && w2_q == '0));

  // R5: no reload of the mailbox while it stays busy
  a_r5_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(w0_q));

  // R4: wake lasts one cycle
  a_r4_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  // R6: owner line low while busy frees the slot on the next edge
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !lines[act_q]) |=> !busy_q);

endmodule

// File: rtl/ivd_dispatch.sv
module ivd_dispatch #(
  parameter int unsigned N_LINES   = 16,
  parameter int unsigned VEC_W     = ivd_pkg::VEC_BITS,
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned TRAP_W    = 9,
  parameter logic [TRAP_W-1:0] TRAP_CODE = 9'h060
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] dev_irq_i,
  output logic               busy_o,
  output logic [WORD_W-1:0]  mbox_w0_o,
  output logic [WORD_W-1:0]  mbox_w1_o,
  output logic [WORD_W-1:0]  mbox_w2_o,
  output logic               irq_req_o,
  output logic [TRAP_W-1:0]  trap_type_o,
  output logic               wake_o
);

  localparam int unsigned IW = $clog2(N_LINES);

  logic [1:0]         rst_sync;
  logic               rst_int;
  logic [N_LINES-1:0] mapped, cand, grant;
  logic [VEC_W-1:0]   vec_tab [N_LINES];
  logic [IW-1:0]      pick_idx;
  logic               pick_any;
  logic               busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_route
      localparam ivd_pkg::route_t RT = ivd_pkg::route_of(i);
      assign mapped[i]  = RT.hit;
      assign vec_tab[i] = VEC_W'(RT.vec);
    end
  endgenerate

  ivd_line_track #(.N(N_LINES)) u_track (
    .clk    (clk),
    .rst_n  (rst_int),
    .lines  (dev_irq_i),
    .mapped (mapped),
    .busy   (busy),
    .grant  (grant),
    .cand   (cand)
  );

  ivd_pick #(.N(N_LINES)) u_pick (
    .enable (~busy),
    .cand   (cand),
    .grant  (grant),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  ivd_mailbox #(
    .N(N_LINES), .VEC_W(VEC_W), .WORD_W(WORD_W),
    .TRAP_W(TRAP_W), .TRAP_CODE(TRAP_CODE)
  ) u_mbox (
    .clk       (clk),
    .rst_n     (rst_int),
    .fire      (pick_any),
    .fire_idx  (pick_idx),
    .fire_vec  (vec_tab[pick_idx]),
    .lines     (dev_irq_i),
    .busy      (busy),
    .w0        (mbox_w0_o),
    .w1        (mbox_w1_o),
    .w2        (mbox_w2_o),
    .irq_req   (irq_req_o),
    .trap_type (trap_type_o),
    .wake      (wake_o)
  );

  assign busy_o = busy;

  // R7: at most one line granted per cycle
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot0(grant));

  // R2: lines without a translation are never granted
  a_r2_unmapped_idle: assert property (@(posedge clk) disable iff (!rst_int)
    (grant & ~mapped) == '0);

  // R5: nothing is granted while the slot is occupied
  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_int)
    busy |-> (grant == '0));

  // R7: the granted line has no lower-numbered candidate
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rst_int)
    pick_any |-> ((cand & (grant - 1'b1)) == '0));

endmodule

// File: tb/tb_ivd_dispatch.sv
module tb_ivd_dispatch;

  localparam int unsigned N = 16;
  localparam int unsigned W = 64;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  lines;
  logic          busy_o, irq_req_o, wake_o;
  logic [W-1:0]  w0, w1, w2;
  logic [8:0]    trap;

  int n_chk;
  int n_bad;
  bit done;
  logic [W-1:0] exp_q[$];

  ivd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .dev_irq_i(lines),
    .busy_o(busy_o), .mbox_w0_o(w0), .mbox_w1_o(w1), .mbox_w2_o(w2),
    .irq_req_o(irq_req_o), .trap_type_o(trap), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input int line);
    case (line)
      1:  return 64'h7E9;
      4:  return 64'h7EB;
      6:  return 64'h7E7;
      7:  return 64'h7E2;
      12: return 64'h7EA;
      default: return 64'h0;
    endcase
  endfunction

  // driver helper: expect a delivery
  task automatic expect_line(input int line);
    exp_q.push_back(word_of(line));
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // monitor: compare each delivery against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && wake_o) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R2/R5 unexpected delivery: actual %0h expected none", w0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk("R1 word0", w0, e);
        chk("R3 word1", w1, 0);
        chk("R3 word2", w2, 0);
        chk("R3 irq", {63'b0, irq_req_o}, 1);
        chk("R3 trap", {55'b0, trap}, 64'h060);
        chk("R3 busy", {63'b0, busy_o}, 1);
      end
    end
  end

  task automatic idle_state(input string req);
    chk({req, " busy"}, {63'b0, busy_o}, 0);
    chk({req, " irq"},  {63'b0, irq_req_o}, 0);
    chk({req, " trap"}, {55'b0, trap}, 0);
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    lines = '0;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R9: reset state
    idle_state("R9");
    chk("R9 word0", w0, 0);
    chk("R9 word1", w1, 0);
    chk("R9 word2", w2, 0);
    chk("R9 wake", {63'b0, wake_o}, 0);

    // R1, R3, R4, R6: each mapped line on its own
    foreach (word_of_list[j]) begin end
    for (int li = 0; li < N; li++) begin
      if (word_of(li) != 0) begin
        expect_line(li);
        lines[li] = 1'b1;
        cyc(1);
        chk("R4 wake on", {63'b0, wake_o}, 1);
        cyc(1);
        chk("R4 wake off", {63'b0, wake_o}, 0);
        lines[li] = 1'b0;
        cyc(1);
        idle_state("R6");
        chk("R3 word0 held", w0, word_of(li));
      end
    end

    // R2: unmapped lines ignored
    lines = 16'hEFAD & ~16'h10D2;
    lines = 16'b1110_1111_0010_1101;
    cyc(3);
    idle_state("R2");
    lines = '0;
    cyc(3);
    idle_state("R2 fall");
    chk("R2 word0 unchanged", w0, word_of(12));

    // R5: raise while busy dropped
    expect_line(4);
    lines[4] = 1'b1;
    cyc(2);
    lines[1] = 1'b1;
    cyc(2);
    chk("R5 word0 kept", w0, word_of(4));
    lines[4] = 1'b0;
    cyc(3);
    idle_state("R5 dropped");
    lines[1] = 1'b0;
    cyc(2);

    // R6: other lines falling have no effect
    expect_line(6);
    lines[6] = 1'b1;
    cyc(2);
    lines[12] = 1'b1; lines[0] = 1'b1;
    cyc(2);
    lines[12] = 1'b0; lines[0] = 1'b0;
    cyc(2);
    chk("R6 still busy", {63'b0, busy_o}, 1);
    lines[6] = 1'b0;
    cyc(1);
    idle_state("R6 owner");
    cyc(1);

    // R7: simultaneous raises, lowest first
    expect_line(1); expect_line(7); expect_line(12);
    lines[12] = 1'b1; lines[7] = 1'b1; lines[1] = 1'b1;
    cyc(2);
    chk("R7 first", w0, word_of(1));
    lines[1] = 1'b0;
    cyc(3);
    chk("R7 second", w0, word_of(7));
    lines[7] = 1'b0;
    cyc(3);
    chk("R7 third", w0, word_of(12));
    lines[12] = 1'b0;
    cyc(2);
    idle_state("R7 end");

    // R8: pending line that falls is discarded
    expect_line(4);
    lines[4] = 1'b1; lines[6] = 1'b1;
    cyc(2);
    lines[6] = 1'b0;
    cyc(1);
    lines[4] = 1'b0;
    cyc(4);
    idle_state("R8");

    // R10: release and new raise in the same cycle
    expect_line(1);
    lines[1] = 1'b1;
    cyc(2);
    lines[1] = 1'b0; lines[7] = 1'b1;
    cyc(4);
    idle_state("R10 dropped");
    lines[7] = 1'b0;
    cyc(2);
    expect_line(1); expect_line(7);
    lines[1] = 1'b1;
    cyc(2);
    lines[1] = 1'b0;
    cyc(1);
    lines[7] = 1'b1;
    cyc(1);
    chk("R10 next cycle raise", w0, word_of(7));
    lines[7] = 1'b0;
    cyc(2);

    // R9: reset in the middle of a delivery
    expect_line(4);
    lines[4] = 1'b1;
    cyc(2);
    rst_n = 1'b0;
    #1;
    idle_state("R9 mid");
    chk("R9 mid word0", w0, 0);
    lines = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    idle_state("R9 after");

    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 missing deliveries: actual %0d expected 0", exp_q.size());
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  int word_of_list[1];

endmodule